// File: doc/BRIEF.md
# Instruction Address Generation Unit

This block produces the word address that a small processor presents to its memory and owns the program counter. Every cycle a two-bit source select picks the address from one of four places: the program counter, the memory address register value supplied from outside, or one of two short register-number fields of the current instruction. These fields are the index field and the accumulator field. A short field is widened to a full address by filling the upper bits with zeros, so general registers occupy the lowest words of memory. Memory words are 36 bits wide and addresses are 18 bits wide.

The program counter is an 18-bit register that holds the address of the next instruction to fetch. A sequencer outside the block asserts a step enable when the counter should advance. Each step either adds one to the counter, wrapping modulo 2^18, or, when the jump input is high, loads the memory address register value as the jump target. The address output is combinational from the select and the sources. The block also gives the low address bits that index the attached 32-word test memory.

Top module: `pc_addr_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter is cleared to zero, and it reads zero in the following cycle.
- R2: With `src_sel` = 2'b00, `mem_addr` equals the current program counter value within the same cycle.
- R3: With `src_sel` = 2'b01, `mem_addr` equals `mar_val` within the same cycle.
- R4: With `src_sel` = 2'b10, `mem_addr[3:0]` equals `idx_fld` and `mem_addr[17:4]` is zero.
- R5: With `src_sel` = 2'b11, `mem_addr[3:0]` equals `acc_fld` and `mem_addr[17:4]` is zero.
- R6: At a rising edge with `pc_step` high and `pc_jump` low, the program counter becomes its previous value plus one.
- R7: At a rising edge with `pc_step` high and `pc_jump` high, the program counter becomes the `mar_val` sampled at that edge.
- R8: At a rising edge with `pc_step` low, the program counter keeps its value whatever `pc_jump` and `mar_val` are.
- R9: Incrementing from 18'h3FFFF gives 18'h00000.
- R10: `mem_word_idx` equals `mem_addr[4:0]` in every cycle, for every source.
- R11: In a cycle where `src_sel` = 2'b00 and the program counter steps, `mem_addr` shows the value from before the step, and the new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Address source: 00 PC, 01 MA, 10 index field, 11 accumulator field |
| mar_val | input | 18 | Memory address register value, also the jump target |
| idx_fld | input | 4 | Index register number from the instruction |
| acc_fld | input | 4 | Accumulator register number from the instruction |
| pc_step | input | 1 | Advance the program counter at this edge |
| pc_jump | input | 1 | During a step, load `mar_val` instead of PC+1 |
| mem_addr | output | 18 | Selected memory word address |
| mem_word_idx | output | 5 | Low address bits for the 32-word memory |
| pc_q | output | 18 | Current program counter |

## Verification
The address path and the counter update share a cycle when the counter is selected as the source while a step is requested. The address must then show the counter before the step, and the stepped value must appear only once the edge has passed. The bench provokes this with directed cycles that select 00 and raise `pc_step`, both with and without `pc_jump`, and with many random cycles that mix select and step. It compares `mem_addr` ahead of the edge with its own pre-edge counter model and compares `pc_q` after the edge with the model's post-edge value. Directed cases also cover the wrap at the top of the address space and a jump whose target is the highest address.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned ADDR_W_DEF  = 18;
  localparam int unsigned WORD_W_DEF  = 36;
  localparam int unsigned FIELD_W_DEF = 4;
  localparam int unsigned MEM_WORDS_DEF = 32;

  typedef enum logic [1:0] {
    SRC_PC  = 2'b00,
    SRC_MA  = 2'b01,
    SRC_IDX = 2'b10,
    SRC_ACC = 2'b11
  } addr_src_e;
endpackage

// File: rtl/pcu_addr_mux.sv
module pcu_addr_mux
  import pcu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W_DEF,
  parameter int unsigned FW = FIELD_W_DEF
) (
  input  addr_src_e        sel,
  input  logic [AW-1:0]    pc_val,
  input  logic [AW-1:0]    ma_val,
  input  logic [FW-1:0]    idx_val,
  input  logic [FW-1:0]    acc_val,
  output logic [AW-1:0]    addr
);
  localparam int unsigned PAD_W = (AW > FW) ? AW - FW : 0;

  logic [AW-1:0] idx_wide;
  logic [AW-1:0] acc_wide;

  // Short register numbers become low-memory word addresses.
  generate
    if (PAD_W > 0) begin : g_pad
      assign idx_wide = {{PAD_W{1'b0}}, idx_val};
      assign acc_wide = {{PAD_W{1'b0}}, acc_val};
    end else begin : g_trunc
      assign idx_wide = idx_val[AW-1:0];
      assign acc_wide = acc_val[AW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SRC_PC:  addr = pc_val;
      SRC_MA:  addr = ma_val;
      SRC_IDX: addr = idx_wide;
      SRC_ACC: addr = acc_wide;
      default: addr = pc_val;
    endcase
  end
endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc #(
  parameter int unsigned AW = 18
) (
  input  logic [AW-1:0] pc_cur,
  input  logic [AW-1:0] jump_tgt,
  input  logic          take_jump,
  output logic [AW-1:0] pc_nxt
);
  logic [AW-1:0] pc_inc;

  // Wraps naturally modulo 2^AW.
  assign pc_inc = pc_cur + {{(AW-1){1'b0}}, 1'b1};
  assign pc_nxt = take_jump ? jump_tgt : pc_inc;
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int unsigned AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/pc_addr_unit.sv
module pc_addr_unit
  import pcu_pkg::*;
#(
  parameter int unsigned AW        = ADDR_W_DEF,
  parameter int unsigned FW        = FIELD_W_DEF,
  parameter int unsigned MEM_WORDS = MEM_WORDS_DEF,
  localparam int unsigned IW       = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    src_sel,
  input  logic [AW-1:0] mar_val,
  input  logic [FW-1:0] idx_fld,
  input  logic [FW-1:0] acc_fld,
  input  logic          pc_step,
  input  logic          pc_jump,
  output logic [AW-1:0] mem_addr,
  output logic [IW-1:0] mem_word_idx,
  output logic [AW-1:0] pc_q
);
  logic [AW-1:0] pc_d;
  addr_src_e     sel_e;

  assign sel_e = addr_src_e'(src_sel);

  pcu_addr_mux #(.AW(AW), .FW(FW)) mux_i (
    .sel     (sel_e),
    .pc_val  (pc_q),
    .ma_val  (mar_val),
    .idx_val (idx_fld),
    .acc_val (acc_fld),
    .addr    (mem_addr)
  );

  pcu_next_pc #(.AW(AW)) nxt_i (
    .pc_cur    (pc_q),
    .jump_tgt  (mar_val),
    .take_jump (pc_jump),
    .pc_nxt    (pc_d)
  );

  pcu_pc_reg #(.AW(AW)) pc_i (
    .clk (clk),
    .rst (rst),
    .en  (pc_step),
    .d   (pc_d),
    .q   (pc_q)
  );

  assign mem_word_idx = mem_addr[IW-1:0];
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int unsigned AW = 18,
  parameter int unsigned FW = 4,
  parameter int unsigned IW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    src_sel,
  input logic [AW-1:0] mar_val,
  input logic [FW-1:0] idx_fld,
  input logic [FW-1:0] acc_fld,
  input logic          pc_step,
  input logic          pc_jump,
  input logic [AW-1:0] mem_addr,
  input logic [IW-1:0] mem_word_idx,
  input logic [AW-1:0] pc_q
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

  a_r2_pc_source: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b00) |-> (mem_addr == pc_q));

  a_r3_ma_source: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b01) |-> (mem_addr == mar_val));

  a_r4_idx_source: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b10) |-> (mem_addr[AW-1:FW] == '0 && mem_addr[FW-1:0] == idx_fld));

  a_r5_acc_source: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b11) |-> (mem_addr[AW-1:FW] == '0 && mem_addr[FW-1:0] == acc_fld));

  a_r6_increment: assert property (@(posedge clk) disable iff (rst)
    (pc_step && !pc_jump) |=> (pc_q == $past(pc_q) + ONE));

  a_r7_jump_load: assert property (@(posedge clk) disable iff (rst)
    (pc_step && pc_jump) |=> (pc_q == $past(mar_val)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_step |=> $stable(pc_q));

  a_r10_word_index: assert property (@(posedge clk) disable iff (rst)
    mem_word_idx == mem_addr[IW-1:0]);
endmodule

bind pc_addr_unit pcu_checker #(.AW(AW), .FW(FW), .IW(IW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .src_sel      (src_sel),
  .mar_val      (mar_val),
  .idx_fld      (idx_fld),
  .acc_fld      (acc_fld),
  .pc_step      (pc_step),
  .pc_jump      (pc_jump),
  .mem_addr     (mem_addr),
  .mem_word_idx (mem_word_idx),
  .pc_q         (pc_q)
);

// File: tb/pc_addr_unit_tb.sv
`timescale 1ns/1ps
module pc_addr_unit_tb_top;
  localparam int AW = 18;
  localparam int FW = 4;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    src_sel = 2'b00;
  logic [AW-1:0] mar_val = '0;
  logic [FW-1:0] idx_fld = '0;
  logic [FW-1:0] acc_fld = '0;
  logic          pc_step = 1'b0;
  logic          pc_jump = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [IW-1:0] mem_word_idx;
  logic [AW-1:0] pc_q;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] model_pc = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pc_addr_unit dut_i (
    .clk(clk), .rst(rst), .src_sel(src_sel), .mar_val(mar_val),
    .idx_fld(idx_fld), .acc_fld(acc_fld), .pc_step(pc_step), .pc_jump(pc_jump),
    .mem_addr(mem_addr), .mem_word_idx(mem_word_idx), .pc_q(pc_q)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [1:0] s, input logic [AW-1:0] pc,
                                             input logic [AW-1:0] ma, input logic [FW-1:0] xf,
                                             input logic [FW-1:0] af);
    case (s)
      2'b00:   return pc;
      2'b01:   return ma;
      2'b10:   return {{(AW-FW){1'b0}}, xf};
      default: return {{(AW-FW){1'b0}}, af};
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] pc, input logic st,
                                             input logic jp, input logic [AW-1:0] ma);
    if (!st) return pc;
    if (jp)  return ma;
    return pc + 18'd1;
  endfunction

  function automatic string src_req(input logic [1:0] s);
    case (s)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check the address before the
  // rising edge, then check the counter after it.
  task automatic run_cycle(input logic [1:0] s, input logic [AW-1:0] ma,
                           input logic [FW-1:0] xf, input logic [FW-1:0] af,
                           input logic st, input logic jp, input string upd_req);
    logic [AW-1:0] ea;
    @(negedge clk);
    src_sel = s; mar_val = ma; idx_fld = xf; acc_fld = af; pc_step = st; pc_jump = jp;
    #1;
    ea = exp_addr(s, model_pc, ma, xf, af);
    check(src_req(s), mem_addr, ea);
    check("R10", {{(AW-IW){1'b0}}, mem_word_idx}, {{(AW-IW){1'b0}}, ea[IW-1:0]});
    model_pc = exp_next(model_pc, st, jp, ma);
    @(posedge clk);
    #1;
    check(upd_req, pc_q, model_pc);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", pc_q, '0);
    @(negedge clk);
    rst = 1'b0;
    model_pc = '0;

    // Directed: every source, then increments.
    run_cycle(2'b00, 18'h12345, 4'hA, 4'h5, 1'b0, 1'b0, "R8");
    run_cycle(2'b01, 18'h2ABCD, 4'hA, 4'h5, 1'b0, 1'b1, "R8");
    run_cycle(2'b10, 18'h3FFFF, 4'hF, 4'h0, 1'b0, 1'b0, "R8");
    run_cycle(2'b11, 18'h3FFFF, 4'h0, 4'hF, 1'b0, 1'b0, "R8");
    run_cycle(2'b00, 18'h00000, 4'h1, 4'h2, 1'b1, 1'b0, "R6");
    run_cycle(2'b00, 18'h00000, 4'h1, 4'h2, 1'b1, 1'b0, "R11");
    // Jump to the top address, then wrap on increment.
    run_cycle(2'b00, 18'h3FFFF, 4'h3, 4'h4, 1'b1, 1'b1, "R7");
    run_cycle(2'b00, 18'h11111, 4'h3, 4'h4, 1'b1, 1'b0, "R9");
    run_cycle(2'b01, 18'h0001F, 4'h3, 4'h4, 1'b0, 1'b1, "R8");
    run_cycle(2'b00, 18'h2AAAA, 4'h3, 4'h4, 1'b1, 1'b1, "R11");

    // Random mix of sources and steps.
    for (int i = 0; i < 400; i++) begin
      logic [1:0]    s;
      logic [AW-1:0] ma;
      logic          st, jp;
      s  = 2'($urandom_range(0, 3));
      ma = AW'($urandom);
      st = ($urandom_range(0, 3) != 0);
      jp = ($urandom_range(0, 3) == 0);
      run_cycle(s, ma, 4'($urandom), 4'($urandom), st, jp,
                !st ? "R8" : (jp ? "R7" : "R6"));
    end

    // Reset in mid-run clears the counter again.
    @(negedge clk);
    rst = 1'b1; pc_step = 1'b1; pc_jump = 1'b0;
    @(posedge clk);
    #1;
    check("R1", pc_q, '0);
    @(negedge clk);
    rst = 1'b0; pc_step = 1'b0;
    model_pc = '0;
    run_cycle(2'b00, 18'h00000, 4'h0, 4'h0, 1'b1, 1'b0, "R6");

    done = 1'b1;
  end

  initial begin : watchdog
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule